// File: doc/BRIEF.md
# SGMII Configuration Word Exchanger

This block runs the status handshake that an SGMII link performs in place of an ordinary auto-negotiation ability exchange. It works on 16-bit configuration words that are already decoded from, or not yet encoded into, the 8b/10b line code. On the PHY side it turns local link, duplex and speed status into an outgoing status word. It waits for the far end to return an acknowledge, then sets its own acknowledge bit. After a settling interval timed by a link timer, it reports completion. Any change in the local status starts the exchange again.

A mode pin switches the block to the MAC side. There it qualifies the incoming status words, latches the partner's link, duplex and speed, and answers with the fixed acknowledge word. A received word is only acted upon once the same word has arrived three times in a row on valid cycles, with the acknowledge bit left out of the comparison. Loss of receive synchronisation sends either side back to its starting point. The mode pin is expected to stay fixed while the block is out of reset.

Top module: `sgmii_cfg_xchg`

## Requirements
- R1: In PHY mode each transmitted word carries the status sampled one cycle earlier: bit 15 is link (1 = up), bit 12 is duplex (1 = full), bits 11:10 are speed (2'b10 = 1000 Mb/s, 2'b01 = 100 Mb/s, 2'b00 = 10 Mb/s), bits 13 and 9:1 are 0 and bit 0 is 1.
- R2: A received word is matched only after three consecutive valid words that are identical with bit 14 masked out. A different word restarts the count. An acknowledge is a matched word whose most recent copy has bit 14 set.
- R3: In PHY mode, one cycle after an acknowledge is matched, the transmitted word gains bit 14 = 1. For link up, full duplex and 1000 Mb/s this gives 16'hD801.
- R4: an_complete rises exactly LINK_TIMER_CYCLES cycles after the cycle in which the outgoing acknowledge state was entered, and it stays low before that.
- R5: In PHY mode a change of link, duplex or speed restarts the exchange. One cycle later the word carries the new status with bit 14 = 0 and an_complete = 0, and acknowledges matched earlier no longer count.
- R6: In MAC mode the block transmits 16'h0001 until it matches a valid status word, and 16'h4001 after that.
- R7: In MAC mode, one cycle after a valid word is matched, lp_link, lp_duplex and lp_speed hold bits 15, 12 and 11:10 of that word. an_complete follows after the link timer. A later matched word that differs (bit 14 ignored) is latched again and restarts the timer.
- R8: In MAC mode a matched word with speed bits 2'b11 leaves lp_link, lp_duplex and lp_speed unchanged, sets speed_err, clears an_complete and returns the word to 16'h0001. The next valid matched word clears speed_err.
- R9: While rst is high, and one cycle after rx_sync goes low, tx_config_valid, tx_config and an_complete are 0. When synchronisation returns, the word restarts without acknowledge and the match count starts from zero.
- R10: rx_config is ignored on cycles where rx_config_valid is low. Such cycles neither break nor advance a run of matching words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_phy | input | 1 | 1 = PHY side, 0 = MAC side |
| rx_sync | input | 1 | Receive synchronisation from the decoder |
| stat_link | input | 1 | Local link status (PHY side) |
| stat_duplex | input | 1 | Local duplex status (PHY side) |
| stat_speed | input | 2 | Local speed code (PHY side) |
| rx_config | input | 16 | Decoded received configuration word |
| rx_config_valid | input | 1 | rx_config holds a new word |
| tx_config | output | 16 | Configuration word toward the encoder |
| tx_config_valid | output | 1 | tx_config is to be sent |
| an_complete | output | 1 | Exchange finished |
| lp_link | output | 1 | Latched partner link (MAC side) |
| lp_duplex | output | 1 | Latched partner duplex (MAC side) |
| lp_speed | output | 2 | Latched partner speed (MAC side) |
| speed_err | output | 1 | Matched word carried the reserved speed code |

## Verification
The properties assume that mode_phy is held steady from reset onward and that stat_speed never carries the reserved code 2'b11. Several of them also compare the outgoing word against the status sampled one clock earlier, which assumes the status inputs are synchronous to clk. The bench changes mode_phy only while rst is asserted. It drives only the three legal speed codes and changes every input at the falling clock edge. The reserved code appears only in received words, where the block is required to reject it.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  localparam int CFG_W     = 16;
  localparam int ACK_BIT   = 14;
  localparam int LINK_BIT  = 15;
  localparam int DUP_BIT   = 12;
  localparam int SPD_LO    = 10;
  localparam int SPD_HI    = 11;

  localparam logic [1:0]       SPD_RESERVED  = 2'b11;
  localparam logic [CFG_W-1:0] MAC_IDLE_WORD = 16'h0001;
  localparam logic [CFG_W-1:0] MAC_ACK_WORD  = 16'h4001;
  localparam logic [CFG_W-1:0] ACK_MASK      = ~(CFG_W'(1) << ACK_BIT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACKD = 2'd2,
    ST_DONE = 2'd3
  } xchg_state_t;

  function automatic logic [CFG_W-1:0] phy_word(input logic link, input logic dup,
                                                input logic [1:0] spd, input logic ack);
    return {link, ack, 1'b0, dup, spd, 9'b0, 1'b1};
  endfunction
endpackage

// File: rtl/sgx_word_match.sv
module sgx_word_match #(
  parameter int WORD_W  = 16,
  parameter int MATCH_N = 3,
  parameter int IGN_POS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              matched,
  output logic [WORD_W-1:0] m_word
);
  localparam int CNT_W = $clog2(MATCH_N + 1);
  localparam logic [WORD_W-1:0] CMP_MASK = ~(WORD_W'(1) << IGN_POS);
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(MATCH_N);

  logic [CNT_W-1:0] run_cnt;
  logic             same;

  assign same    = (run_cnt != '0) && ((in_word & CMP_MASK) == (m_word & CMP_MASK));
  assign matched = (run_cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_cnt <= '0;
      m_word  <= '0;
    end else if (in_valid) begin
      m_word <= in_word;
      if (!same)
        run_cnt <= CNT_W'(1);
      else if (run_cnt != CNT_TOP)
        run_cnt <= run_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sgx_link_timer.sv
module sgx_link_timer #(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sgx_sequencer.sv
module sgx_sequencer
  import sgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_phy,
  input  logic             rx_sync,
  input  logic             stat_link,
  input  logic             stat_duplex,
  input  logic [1:0]       stat_speed,
  input  logic             matched,
  input  logic [CFG_W-1:0] m_word,
  input  logic             tmr_expired,
  output logic             tmr_start,
  output logic             match_clr,
  output logic [CFG_W-1:0] tx_config,
  output logic             tx_config_valid,
  output logic             an_complete,
  output logic             lp_link,
  output logic             lp_duplex,
  output logic [1:0]       lp_speed,
  output logic             speed_err
);
  xchg_state_t      state, st_n;
  logic [3:0]       snap, stat_now;
  logic [CFG_W-1:0] lat_core, m_core;
  logic             status_chg, m_resv, m_new, latch, err_set;

  always_comb begin
    stat_now   = {stat_link, stat_duplex, stat_speed};
    status_chg = (stat_now != snap);
    m_core     = m_word & ACK_MASK;
    m_resv     = (m_word[SPD_HI:SPD_LO] == SPD_RESERVED);
    m_new      = matched && (m_core != lat_core);
    st_n       = state;
    tmr_start  = 1'b0;
    match_clr  = 1'b0;
    latch      = 1'b0;
    err_set    = 1'b0;
    case (state)
      ST_IDLE: begin
        st_n      = ST_SEND;
        match_clr = 1'b1;
      end
      ST_SEND: begin
        if (mode_phy) begin
          if (status_chg) match_clr = 1'b1;
          else if (matched && m_word[ACK_BIT]) begin
            st_n      = ST_ACKD;
            tmr_start = 1'b1;
          end
        end else if (matched) begin
          if (m_resv) err_set = 1'b1;
          else begin
            latch     = 1'b1;
            st_n      = ST_ACKD;
            tmr_start = 1'b1;
          end
        end
      end
      default: begin
        if (mode_phy && status_chg) begin
          st_n      = ST_SEND;
          match_clr = 1'b1;
        end else if (!mode_phy && m_new) begin
          if (m_resv) begin
            st_n    = ST_SEND;
            err_set = 1'b1;
          end else begin
            latch     = 1'b1;
            st_n      = ST_ACKD;
            tmr_start = 1'b1;
          end
        end else if (state == ST_ACKD && tmr_expired) begin
          st_n = ST_DONE;
        end
      end
    endcase
    if (!rx_sync) begin
      st_n      = ST_IDLE;
      match_clr = 1'b1;
      tmr_start = 1'b0;
      latch     = 1'b0;
      err_set   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      snap            <= '0;
      tx_config       <= '0;
      tx_config_valid <= 1'b0;
      an_complete     <= 1'b0;
      lp_link         <= 1'b0;
      lp_duplex       <= 1'b0;
      lp_speed        <= '0;
      speed_err       <= 1'b0;
      lat_core        <= '0;
    end else begin
      state           <= st_n;
      snap            <= stat_now;
      tx_config_valid <= (st_n != ST_IDLE);
      an_complete     <= (st_n == ST_DONE);
      if (st_n == ST_IDLE)
        tx_config <= '0;
      else if (mode_phy)
        tx_config <= phy_word(stat_link, stat_duplex, stat_speed, st_n != ST_SEND);
      else
        tx_config <= (st_n == ST_SEND) ? MAC_IDLE_WORD : MAC_ACK_WORD;
      if (latch) begin
        lp_link   <= m_word[LINK_BIT];
        lp_duplex <= m_word[DUP_BIT];
        lp_speed  <= m_word[SPD_HI:SPD_LO];
        lat_core  <= m_core;
        speed_err <= 1'b0;
      end else if (err_set) begin
        speed_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgmii_cfg_xchg.sv
module sgmii_cfg_xchg
  import sgx_pkg::*;
#(
  parameter int LINK_TIMER_CYCLES = 200000,
  parameter int MATCH_COUNT       = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_phy,
  input  logic        rx_sync,
  input  logic        stat_link,
  input  logic        stat_duplex,
  input  logic [1:0]  stat_speed,
  input  logic [15:0] rx_config,
  input  logic        rx_config_valid,
  output logic [15:0] tx_config,
  output logic        tx_config_valid,
  output logic        an_complete,
  output logic        lp_link,
  output logic        lp_duplex,
  output logic [1:0]  lp_speed,
  output logic        speed_err
);
  logic             matched, tmr_start, tmr_expired, match_clr;
  logic [CFG_W-1:0] m_word;

  sgx_word_match #(.WORD_W(CFG_W), .MATCH_N(MATCH_COUNT), .IGN_POS(ACK_BIT)) u_match (
    .clk(clk), .rst(rst), .clr(match_clr), .in_valid(rx_config_valid),
    .in_word(rx_config), .matched(matched), .m_word(m_word)
  );

  sgx_link_timer #(.LIMIT(LINK_TIMER_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .expired(tmr_expired)
  );

  sgx_sequencer u_seq (
    .clk(clk), .rst(rst), .mode_phy(mode_phy), .rx_sync(rx_sync),
    .stat_link(stat_link), .stat_duplex(stat_duplex), .stat_speed(stat_speed),
    .matched(matched), .m_word(m_word), .tmr_expired(tmr_expired),
    .tmr_start(tmr_start), .match_clr(match_clr),
    .tx_config(tx_config), .tx_config_valid(tx_config_valid),
    .an_complete(an_complete), .lp_link(lp_link), .lp_duplex(lp_duplex),
    .lp_speed(lp_speed), .speed_err(speed_err)
  );
endmodule

// File: rtl/sgmii_cfg_xchg_chk.sv
module sgmii_cfg_xchg_chk (
  input logic        clk,
  input logic        rst,
  input logic        mode_phy,
  input logic        rx_sync,
  input logic        stat_link,
  input logic        stat_duplex,
  input logic [1:0]  stat_speed,
  input logic [15:0] tx_config,
  input logic        tx_config_valid,
  input logic        an_complete,
  input logic        lp_link,
  input logic        lp_duplex,
  input logic [1:0]  lp_speed,
  input logic        speed_err
);
  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (rst)
    mode_phy && tx_config_valid |-> !tx_config[13] && tx_config[9:1] == 9'd0 && tx_config[0]);

  p_status_fields_r1: assert property (@(posedge clk) disable iff (rst)
    mode_phy && tx_config_valid |-> tx_config[15] == $past(stat_link)
      && tx_config[12] == $past(stat_duplex) && tx_config[11:10] == $past(stat_speed));

  p_complete_has_ack_r4: assert property (@(posedge clk) disable iff (rst)
    an_complete |-> tx_config_valid && tx_config[14]);

  p_restart_on_change_r5: assert property (@(posedge clk) disable iff (rst)
    mode_phy && rx_sync && $past(rx_sync)
      && {stat_link, stat_duplex, stat_speed} != $past({stat_link, stat_duplex, stat_speed})
      |=> !an_complete && !tx_config[14]);

  p_mac_words_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_phy && tx_config_valid |-> tx_config == 16'h0001 || tx_config == 16'h4001);

  p_lp_speed_legal_r7: assert property (@(posedge clk) disable iff (rst)
    lp_speed != 2'b11);

  p_err_holds_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    speed_err |-> $stable({lp_link, lp_duplex, lp_speed}) && !an_complete);

  p_sync_loss_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_sync |=> !an_complete && !tx_config_valid && tx_config == 16'h0000);
endmodule

bind sgmii_cfg_xchg sgmii_cfg_xchg_chk u_chk (
  .clk(clk), .rst(rst), .mode_phy(mode_phy), .rx_sync(rx_sync),
  .stat_link(stat_link), .stat_duplex(stat_duplex), .stat_speed(stat_speed),
  .tx_config(tx_config), .tx_config_valid(tx_config_valid),
  .an_complete(an_complete), .lp_link(lp_link), .lp_duplex(lp_duplex),
  .lp_speed(lp_speed), .speed_err(speed_err)
);

// File: tb/sgmii_cfg_xchg_bench.sv
module sgmii_cfg_xchg_bench;
  localparam int CLK_PERIOD = 8;
  localparam int LINK = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_phy = 1'b1;
  logic        rx_sync = 1'b1;
  logic        stat_link = 1'b1;
  logic        stat_duplex = 1'b1;
  logic [1:0]  stat_speed = 2'b10;
  logic [15:0] rx_config = 16'h0000;
  logic        rx_config_valid = 1'b0;
  logic [15:0] tx_config;
  logic        tx_config_valid, an_complete, lp_link, lp_duplex, speed_err;
  logic [1:0]  lp_speed;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgmii_cfg_xchg #(.LINK_TIMER_CYCLES(LINK), .MATCH_COUNT(3)) u_sgmii_cfg_xchg (
    .clk(clk), .rst(rst), .mode_phy(mode_phy), .rx_sync(rx_sync),
    .stat_link(stat_link), .stat_duplex(stat_duplex), .stat_speed(stat_speed),
    .rx_config(rx_config), .rx_config_valid(rx_config_valid),
    .tx_config(tx_config), .tx_config_valid(tx_config_valid),
    .an_complete(an_complete), .lp_link(lp_link), .lp_duplex(lp_duplex),
    .lp_speed(lp_speed), .speed_err(speed_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one valid word, then one invalid cycle carrying junk (R10 on every use)
  task automatic send(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      rx_config = w; rx_config_valid = 1'b1;
      @(negedge clk);
      rx_config = 16'hBEEF ^ w; rx_config_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic phy);
    @(negedge clk);
    rst = 1'b1; mode_phy = phy; rx_sync = 1'b1; rx_config_valid = 1'b0;
    cyc(3);
    chk("R9 reset valid", 32'(tx_config_valid), 0);
    chk("R9 reset complete", 32'(an_complete), 0);
    chk("R9 reset word", 32'(tx_config), 0);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic t_phy_basic;
    stat_link = 1; stat_duplex = 1; stat_speed = 2'b10;
    do_reset(1'b1);
    chk("R1 first word", 32'(tx_config), 32'h9801);
    chk("R9 valid after reset", 32'(tx_config_valid), 1);
    send(16'h4001, 2);
    chk("R2 two words not matched", 32'(tx_config), 32'h9801);
    send(16'h4001, 1);
    chk("R3 ack word", 32'(tx_config), 32'hD801);
    cyc(LINK - 1);
    chk("R4 not yet complete", 32'(an_complete), 0);
    cyc(1);
    chk("R4 complete", 32'(an_complete), 1);
  endtask

  task automatic t_phy_restart;
    stat_duplex = 0; stat_speed = 2'b01;
    cyc(1);
    chk("R5 new status word", 32'(tx_config), 32'h8401);
    chk("R5 complete dropped", 32'(an_complete), 0);
    send(16'h0001, 3);
    chk("R2 matched without ack", 32'(tx_config), 32'h8401);
    send(16'h4001, 1);
    chk("R2 ack bit ignored for match", 32'(tx_config), 32'hC401);
  endtask

  task automatic t_phy_sync;
    rx_sync = 0;
    cyc(1);
    chk("R9 sync loss valid", 32'(tx_config_valid), 0);
    chk("R9 sync loss word", 32'(tx_config), 0);
    chk("R9 sync loss complete", 32'(an_complete), 0);
    rx_sync = 1;
    cyc(1);
    chk("R9 resume word", 32'(tx_config), 32'h8401);
    send(16'h4001, 1);
    send(16'h4003, 1);
    send(16'h4001, 1);
    chk("R2 broken run", 32'(tx_config), 32'h8401);
    send(16'h4001, 2);
    chk("R10 junk ignored, run completes", 32'(tx_config), 32'hC401);
    stat_link = 0; stat_duplex = 0; stat_speed = 2'b00;
    cyc(1);
    chk("R1 link down word", 32'(tx_config), 32'h0001);
  endtask

  task automatic t_mac;
    do_reset(1'b0);
    chk("R6 idle word", 32'(tx_config), 32'h0001);
    send(16'hD801, 3);
    chk("R6 ack word", 32'(tx_config), 32'h4001);
    chk("R7 latched", 32'({lp_link, lp_duplex, lp_speed}), 32'b1110);
    chk("R7 not yet complete", 32'(an_complete), 0);
    cyc(LINK);
    chk("R7 complete", 32'(an_complete), 1);
    send(16'h8C01, 3);
    chk("R8 err flag", 32'(speed_err), 1);
    chk("R8 outputs held", 32'({lp_link, lp_duplex, lp_speed}), 32'b1110);
    chk("R8 complete cleared", 32'(an_complete), 0);
    chk("R8 word back to idle", 32'(tx_config), 32'h0001);
    send(16'h8401, 3);
    chk("R8 err cleared", 32'(speed_err), 0);
    chk("R7 relatched", 32'({lp_link, lp_duplex, lp_speed}), 32'b1001);
    chk("R7 ack again", 32'(tx_config), 32'h4001);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_phy_basic();
    t_phy_restart();
    t_phy_sync();
    t_mac();
    summary();
  end
endmodule